// File: doc/BRIEF.md
# Occupancy-Driven Work-Point Controller

This block counts the packets waiting in one direction's packet queue and chooses between two voltage/frequency work-points from that count. A packet is counted in when the arrival side raises `push_i`. It is counted out when the processing engine's request on `pop_req_i` is granted on `pop_ok_o`. Only the count is kept here. The payload lives elsewhere, so occupancy is always a number of whole packets. Two programmable thresholds form a hysteresis band. A count above the upper bound moves the block to the fast work-point, a count at or below the lower bound returns it to the slow one, and anywhere in between the mode is held.

The chosen mode drives a frequency-select bit and a voltage-select bit. It also paces the engine: in the slow mode a grant is possible only on one service slot in every three, so the fast mode drains three times as quickly. A mode change takes effect on the very next cycle, with no settling delay. Three wrapping counters record the cycles spent in each mode and the number of mode changes; they feed energy estimation. The transmit and receive directions each use their own instance, so each direction has its own mode.

Suggested threshold values are 20 (upper) and 10 (lower). The upper value must be larger than the lower one.

Top module: `pbd_dvfs_ctrl`

## Requirements
- R1: Reset values. After reset the block is in the slow mode, occupancy is 0, `freq_sel_o` and `volt_sel_o` are 0, and all three statistics counters are 0.
- R2: Occupancy counting. Occupancy rises by one for each accepted push and falls by one for each granted pop. A push accepted in the same cycle as a granted pop leaves occupancy unchanged. Occupancy never exceeds `MAX_PKTS`.
- R3: Full and empty edges. A push while occupancy equals `MAX_PKTS` is dropped and `drop_o` is high in that cycle, unless a pop is granted in the same cycle. A pop request while occupancy is 0 is not granted and has no effect.
- R4: Entering the fast mode. When occupancy is strictly greater than `thr_hi_i`, `mode_hi_o` is 1 from the next cycle on.
- R5: Entering the slow mode. When occupancy is less than or equal to `thr_lo_i`, `mode_hi_o` is 0 from the next cycle on. This condition wins if the thresholds are misordered.
- R6: Holding the mode. While occupancy is above `thr_lo_i` and at or below `thr_hi_i`, `mode_hi_o` keeps its previous value.
- R7: Work-point codes. `freq_sel_o` = 0 selects 250 MHz and 1 selects 500 MHz. `volt_sel_o` = 0 selects 1.0 V and 1 selects 1.2 V. Both equal `mode_hi_o`.
- R8: Fast-mode service. In the fast mode, a pop request on a non-empty queue is granted in every cycle.
- R9: Slow-mode service. A slot phase counts 0, 1, 2, 0, … on every cycle, starting at 0 in the first cycle after reset. In the slow mode, a pop request on a non-empty queue is granted only in cycles where the phase is 0.
- R10: Statistics. `cyc_hi_o` counts the cycles spent in the fast mode and `cyc_lo_o` counts the cycles spent in the slow mode. `mode_flips_o` counts mode changes and increments on the same edge at which the mode changes. All three wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | A packet arrives this cycle |
| pop_req_i | input | 1 | The engine asks to take one packet |
| thr_hi_i | input | CNT_W | Upper threshold; the fast mode is entered above it |
| thr_lo_i | input | CNT_W | Lower threshold; the slow mode is entered at or below it |
| pop_ok_o | output | 1 | The pop request is granted this cycle |
| drop_o | output | 1 | The push this cycle was refused because the queue is full |
| occupancy_o | output | CNT_W | Packets currently held |
| mode_hi_o | output | 1 | 1 = fast work-point, 0 = slow work-point |
| freq_sel_o | output | 1 | Frequency select: 0 = 250 MHz, 1 = 500 MHz |
| volt_sel_o | output | 1 | Voltage select: 0 = 1.0 V, 1 = 1.2 V |
| cyc_hi_o | output | STAT_W | Cycles spent in the fast mode |
| cyc_lo_o | output | STAT_W | Cycles spent in the slow mode |
| mode_flips_o | output | STAT_W | Number of mode changes |

## Verification
A push-only burst fills the queue past the upper bound and into overflow. This separates the strict upper comparison from a non-strict one and shows whether drops are flagged. A pop-only drain follows: it shows that every cycle is granted in the fast mode, that the block falls back exactly at the lower bound, and that the one-in-three pacing starts from there. A long empty tail then exercises refused pops. Balanced and random push/pop traffic keeps the count inside the band to test the hold behaviour. A sweep over every ordered pair of small thresholds tries each boundary value against the strict and non-strict comparisons.

// File: rtl/pbd_pkg.sv
`timescale 1ns/1ps
package pbd_pkg;
   typedef enum logic {
      MODE_LO = 1'b0,
      MODE_HI = 1'b1
   } pbd_mode_e;
endpackage

// File: rtl/pbd_occ_ctr.sv
`timescale 1ns/1ps
module pbd_occ_ctr #(
   parameter int MAX_PKTS = 64,
   parameter int CNT_W    = $clog2(MAX_PKTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   output logic [CNT_W-1:0] occ_o,
   output logic             empty_o,
   output logic             drop_o
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PKTS);

   generate
      if (MAX_PKTS < 2) begin : g_bad_depth
         $error("pbd_occ_ctr: MAX_PKTS must be at least 2");
      end
      if ((1 << CNT_W) <= MAX_PKTS) begin : g_bad_width
         $error("pbd_occ_ctr: CNT_W too narrow for MAX_PKTS");
      end
   endgenerate

   logic [CNT_W-1:0] occ_q;
   logic             full;
   logic             take;

   assign full    = (occ_q == CAP);
   assign empty_o = (occ_q == '0);
   // a granted pop frees a place in the same cycle, so a push may still land
   assign take    = push_i && (!full || pop_i);
   assign drop_o  = push_i && !take;
   assign occ_o   = occ_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= '0;
      end else if (take && !pop_i) begin
         occ_q <= occ_q + CNT_W'(1);
      end else if (!take && pop_i) begin
         occ_q <= occ_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/pbd_throttle.sv
`timescale 1ns/1ps
module pbd_throttle #(
   parameter int SLOW_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_i,
   input  logic req_i,
   input  logic empty_i,
   output logic grant_o
);
   generate
      if (SLOW_DIV < 1) begin : g_bad_div
         $error("pbd_throttle: SLOW_DIV must be at least 1");
      end
   endgenerate

   logic slot_open;

   generate
      if (SLOW_DIV == 1) begin : g_nodiv
         assign slot_open = 1'b1;
      end else begin : g_div
         localparam int              PH_W = $clog2(SLOW_DIV);
         localparam logic [PH_W-1:0] LAST = PH_W'(SLOW_DIV - 1);
         logic [PH_W-1:0] ph_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph_q <= '0;
            end else if (ph_q == LAST) begin
               ph_q <= '0;
            end else begin
               ph_q <= ph_q + PH_W'(1);
            end
         end

         assign slot_open = (ph_q == '0);
      end
   endgenerate

   assign grant_o = req_i && !empty_i && (fast_i || slot_open);
endmodule

// File: rtl/pbd_mode_fsm.sv
`timescale 1ns/1ps
module pbd_mode_fsm
   import pbd_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] occ_i,
   input  logic [CNT_W-1:0] thr_hi_i,
   input  logic [CNT_W-1:0] thr_lo_i,
   output pbd_mode_e        mode_o,
   output logic             flip_o
);
   pbd_mode_e mode_q;
   pbd_mode_e mode_d;

   // the lower bound is tested first so that misordered thresholds settle low
   always_comb begin
      mode_d = mode_q;
      if (occ_i <= thr_lo_i) begin
         mode_d = MODE_LO;
      end else if (occ_i > thr_hi_i) begin
         mode_d = MODE_HI;
      end
   end

   assign flip_o = (mode_d != mode_q);
   assign mode_o = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_LO;
      end else begin
         mode_q <= mode_d;
      end
   end
endmodule

// File: rtl/pbd_stats.sv
`timescale 1ns/1ps
module pbd_stats #(
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_i,
   input  logic              flip_i,
   output logic [STAT_W-1:0] hi_cyc_o,
   output logic [STAT_W-1:0] lo_cyc_o,
   output logic [STAT_W-1:0] flips_o
);
   generate
      if (STAT_W < 2) begin : g_bad_stat
         $error("pbd_stats: STAT_W must be at least 2");
      end
   endgenerate

   // one residency counter per mode: index 0 = slow, index 1 = fast
   generate
      for (genvar g = 0; g < 2; g++) begin : g_res
         logic [STAT_W-1:0] n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               n_q <= '0;
            end else if (fast_i == 1'(g)) begin
               n_q <= n_q + STAT_W'(1);
            end
         end
      end
   endgenerate

   logic [STAT_W-1:0] flips_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flips_q <= '0;
      end else if (flip_i) begin
         flips_q <= flips_q + STAT_W'(1);
      end
   end

   assign lo_cyc_o = g_res[0].n_q;
   assign hi_cyc_o = g_res[1].n_q;
   assign flips_o  = flips_q;
endmodule

// File: rtl/pbd_dvfs_ctrl.sv
`timescale 1ns/1ps
module pbd_dvfs_ctrl
   import pbd_pkg::*;
#(
   parameter int MAX_PKTS = 64,
   parameter int SLOW_DIV = 3,
   parameter int STAT_W   = 32,
   localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_req_i,
   input  logic [CNT_W-1:0]  thr_hi_i,
   input  logic [CNT_W-1:0]  thr_lo_i,
   output logic              pop_ok_o,
   output logic              drop_o,
   output logic [CNT_W-1:0]  occupancy_o,
   output logic              mode_hi_o,
   output logic              freq_sel_o,
   output logic              volt_sel_o,
   output logic [STAT_W-1:0] cyc_hi_o,
   output logic [STAT_W-1:0] cyc_lo_o,
   output logic [STAT_W-1:0] mode_flips_o
);
   pbd_mode_e mode;
   logic      fast;
   logic      flip;
   logic      empty;
   logic      grant;

   assign fast = (mode == MODE_HI);

   pbd_throttle #(
      .SLOW_DIV (SLOW_DIV)
   ) u_throttle (
      .clk     (clk),
      .rst_n   (rst_n),
      .fast_i  (fast),
      .req_i   (pop_req_i),
      .empty_i (empty),
      .grant_o (grant)
   );

   pbd_occ_ctr #(
      .MAX_PKTS (MAX_PKTS),
      .CNT_W    (CNT_W)
   ) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_i),
      .pop_i   (grant),
      .occ_o   (occupancy_o),
      .empty_o (empty),
      .drop_o  (drop_o)
   );

   pbd_mode_fsm #(
      .CNT_W (CNT_W)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .occ_i    (occupancy_o),
      .thr_hi_i (thr_hi_i),
      .thr_lo_i (thr_lo_i),
      .mode_o   (mode),
      .flip_o   (flip)
   );

   pbd_stats #(
      .STAT_W (STAT_W)
   ) u_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_i   (fast),
      .flip_i   (flip),
      .hi_cyc_o (cyc_hi_o),
      .lo_cyc_o (cyc_lo_o),
      .flips_o  (mode_flips_o)
   );

   assign pop_ok_o   = grant;
   assign mode_hi_o  = fast;
   // 1 -> 500 MHz, 0 -> 250 MHz ; 1 -> 1.2 V, 0 -> 1.0 V
   assign freq_sel_o = fast;
   assign volt_sel_o = fast;
endmodule

// File: rtl/pbd_dvfs_chk.sv
`timescale 1ns/1ps
module pbd_dvfs_chk #(
   parameter int MAX_PKTS = 64,
   parameter int SLOW_DIV = 3,
   parameter int CNT_W    = 7,
   parameter int STAT_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic [CNT_W-1:0]  thr_hi_i,
   input logic [CNT_W-1:0]  thr_lo_i,
   input logic              pop_ok_o,
   input logic              drop_o,
   input logic [CNT_W-1:0]  occupancy_o,
   input logic              mode_hi_o,
   input logic [STAT_W-1:0] cyc_hi_o,
   input logic [STAT_W-1:0] cyc_lo_o,
   input logic [STAT_W-1:0] mode_flips_o
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PKTS);

   logic              seen;
   logic [STAT_W-1:0] res_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   assign res_sum = cyc_hi_o + cyc_lo_o;

   // R2
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy_o <= CAP);

   // R3
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok_o |-> occupancy_o != '0);

   // R3
   drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> (push_i && occupancy_o == CAP));

   // R4
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && mode_hi_o && !$past(mode_hi_o)) |-> $past(occupancy_o) > $past(thr_hi_i));

   // R5
   fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !mode_hi_o && $past(mode_hi_o)) |-> $past(occupancy_o) <= $past(thr_lo_i));

   // R6
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(occupancy_o) > $past(thr_lo_i) && $past(occupancy_o) <= $past(thr_hi_i))
      |-> mode_hi_o == $past(mode_hi_o));

   // R9
   generate
      if (SLOW_DIV > 1) begin : g_gap
         slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_ok_o && !mode_hi_o) |=> (!pop_ok_o || mode_hi_o));
      end
   endgenerate

   // R10
   residency_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> res_sum == $past(res_sum) + STAT_W'(1));

   // R10
   flip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && mode_hi_o != $past(mode_hi_o)) |-> mode_flips_o == $past(mode_flips_o) + STAT_W'(1));
endmodule

bind pbd_dvfs_ctrl pbd_dvfs_chk #(
   .MAX_PKTS (MAX_PKTS),
   .SLOW_DIV (SLOW_DIV),
   .CNT_W    (CNT_W),
   .STAT_W   (STAT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .push_i       (push_i),
   .thr_hi_i     (thr_hi_i),
   .thr_lo_i     (thr_lo_i),
   .pop_ok_o     (pop_ok_o),
   .drop_o       (drop_o),
   .occupancy_o  (occupancy_o),
   .mode_hi_o    (mode_hi_o),
   .cyc_hi_o     (cyc_hi_o),
   .cyc_lo_o     (cyc_lo_o),
   .mode_flips_o (mode_flips_o)
);

// File: tb/tb_pbd_dvfs_ctrl.sv
`timescale 1ns/1ps
module tb_pbd_dvfs_ctrl;
   localparam int MAX_PKTS = 32;
   localparam int SLOW_DIV = 3;
   localparam int STAT_W   = 32;
   localparam int CNT_W    = $clog2(MAX_PKTS + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              push_i = 1'b0;
   logic              pop_req_i = 1'b0;
   logic [CNT_W-1:0]  thr_hi_i;
   logic [CNT_W-1:0]  thr_lo_i;
   logic              pop_ok_o;
   logic              drop_o;
   logic [CNT_W-1:0]  occupancy_o;
   logic              mode_hi_o;
   logic              freq_sel_o;
   logic              volt_sel_o;
   logic [STAT_W-1:0] cyc_hi_o;
   logic [STAT_W-1:0] cyc_lo_o;
   logic [STAT_W-1:0] mode_flips_o;

   pbd_dvfs_ctrl #(
      .MAX_PKTS (MAX_PKTS),
      .SLOW_DIV (SLOW_DIV),
      .STAT_W   (STAT_W)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (push_i),
      .pop_req_i    (pop_req_i),
      .thr_hi_i     (thr_hi_i),
      .thr_lo_i     (thr_lo_i),
      .pop_ok_o     (pop_ok_o),
      .drop_o       (drop_o),
      .occupancy_o  (occupancy_o),
      .mode_hi_o    (mode_hi_o),
      .freq_sel_o   (freq_sel_o),
      .volt_sel_o   (volt_sel_o),
      .cyc_hi_o     (cyc_hi_o),
      .cyc_lo_o     (cyc_lo_o),
      .mode_flips_o (mode_flips_o)
   );

   always #5 clk = ~clk;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 0;

   // reference state, derived from the requirements
   int    m_cnt = 0;
   int    m_ph = 0;
   int    hi_thr = 20;
   int    lo_thr = 10;
   bit    m_hi = 0;
   bit    m_prev_hi = 0;
   longint m_chi = 0;
   longint m_clo = 0;
   longint m_sw = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit pu, input bit po);
      bit    e_pop;
      bit    e_acc;
      bit    n_hi;
      string mtag;
      push_i    = pu;
      pop_req_i = po;
      thr_hi_i  = CNT_W'(hi_thr);
      thr_lo_i  = CNT_W'(lo_thr);
      #1;
      e_pop = po && (m_cnt != 0) && (m_hi || m_ph == 0);
      e_acc = pu && ((m_cnt < MAX_PKTS) || e_pop);
      chk("R2 occupancy", occupancy_o, m_cnt);
      if (m_hi && !m_prev_hi)      mtag = "R4 mode";
      else if (!m_hi && m_prev_hi) mtag = "R5 mode";
      else                         mtag = "R6 mode";
      chk(mtag, mode_hi_o, m_hi);
      chk("R7 freq_sel", freq_sel_o, m_hi);
      chk("R7 volt_sel", volt_sel_o, m_hi);
      if (m_cnt == 0)   chk("R3 pop on empty", pop_ok_o, e_pop);
      else if (m_hi)    chk("R8 fast grant", pop_ok_o, e_pop);
      else              chk("R9 slow grant", pop_ok_o, e_pop);
      chk("R3 drop", drop_o, pu && !e_acc);
      chk("R10 cyc_hi", cyc_hi_o, m_chi);
      chk("R10 cyc_lo", cyc_lo_o, m_clo);
      chk("R10 flips", mode_flips_o, m_sw);
      // advance the reference by one clock edge
      if (m_cnt <= lo_thr)      n_hi = 0;
      else if (m_cnt > hi_thr)  n_hi = 1;
      else                      n_hi = m_hi;
      if (m_hi) m_chi++; else m_clo++;
      if (n_hi != m_hi) m_sw++;
      m_cnt = m_cnt + (e_acc ? 1 : 0) - (e_pop ? 1 : 0);
      m_prev_hi = m_hi;
      m_hi = n_hi;
      m_ph = (m_ph + 1) % SLOW_DIV;
      @(negedge clk);
   endtask

   task automatic rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      thr_hi_i = CNT_W'(20);
      thr_lo_i = CNT_W'(10);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset values
      chk("R1 occupancy", occupancy_o, 0);
      chk("R1 mode", mode_hi_o, 0);
      chk("R1 freq/volt", {freq_sel_o, volt_sel_o}, 0);
      chk("R1 stats", cyc_hi_o + cyc_lo_o + mode_flips_o, 0);
      // fill past the upper bound into overflow (R4, R3)
      for (int i = 0; i < 40; i++) step(1, 0);
      // balanced traffic at full occupancy (R2)
      for (int i = 0; i < 10; i++) step(1, 1);
      // drain: fast grants, fall at the lower bound, slow pacing, empty pops (R8, R5, R9, R3)
      for (int i = 0; i < 80; i++) step(0, 1);
      // both each cycle from empty: slow pacing lets the count climb (R9, R4)
      for (int i = 0; i < 60; i++) step(1, 1);
      // random traffic around the band (R6)
      for (int i = 0; i < 3000; i++) begin
         rnd();
         step(lfsr[0], lfsr[3]);
      end
      // reprogrammed thresholds with push-heavy traffic
      hi_thr = 6;
      lo_thr = 3;
      for (int i = 0; i < 2000; i++) begin
         rnd();
         step(lfsr[1:0] != 2'b00, lfsr[5]);
      end
      // every ordered pair of small thresholds
      for (int h = 1; h <= 8; h++) begin
         for (int l = 0; l < h; l++) begin
            hi_thr = h;
            lo_thr = l;
            for (int i = 0; i < 100; i++) begin
               rnd();
               step(lfsr[2], lfsr[7] | lfsr[9]);
            end
         end
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(500_000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule